// File: doc/BRIEF.md
# Byte-Lane Masked Single-Port RAM

This block is a synchronous single-port memory whose word is split into independently writable byte lanes. Each lane has its own enable bit, so a write can update any subset of the lanes while the remaining lanes keep their stored value. The read output is registered. During a write, every lane of the output is fully defined:

- A lane that is masked off shows the byte already stored at that address.
- A lane that is written shows either the incoming byte or the byte it replaces. A build-time parameter chooses which.

All inputs are captured on a rising edge, and the memory is accessed on the following edge. The address register has a stall input. While the stall input is high, the register keeps its current contents instead of loading a new address. Reads and writes issued during a stall both target the held address. The block is meant as a storage primitive for datapaths that perform partial-word updates and need a predictable output while doing so.

Top module: `bytelane_ram`

## Requirements
- R1: A synchronous active-low reset clears the read output to zero and cancels any pending read or write. The memory contents are not cleared.
- R2: Inputs are captured on one rising edge. The memory access and the output update happen on the next rising edge, so the result is visible two edges after the inputs are presented.
- R3: During a write, a lane whose enable bit is 0 keeps its stored byte, and that lane of the output shows the stored byte.
- R4: With the policy set to new-data, a written lane shows the incoming byte on the output during the write.
- R5: With the policy set to old-data, a written lane shows the byte it replaces on the output during the write.
- R6: Enable bit 1 governs bits 15:8 and enable bit 0 governs bits 7:0. Starting from a stored FFFF, writing ABCD leaves the following: enable 10 leaves ABFF, enable 01 leaves FFCD, and enable 11 leaves ABCD.
- R7: While the stall input is 1, the address register keeps its previous value. While the stall input is 0, it loads the presented address on each edge.
- R8: A write issued during a stall lands at the held address, and the presented address is left unchanged.
- R9: When neither a read nor a write is pending, the output holds its last value.
- R10: A read without a write returns the full stored word at the registered address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| lane_en | input | LANES (2) | Per-lane write enable; bit 1 = high byte |
| addr | input | ADDR_W (9) | Word address |
| addr_stall | input | 1 | 1 = keep the previously registered address |
| wdata | input | LANES*LANE_W (16) | Write data |
| rdata | output | LANES*LANE_W (16) | Registered read data |

## Verification
The following are checked by assertions on every edge:

- The address register holds during a stall and loads when there is no stall.
- The output stays stable when nothing is pending.
- The output clears after reset.
- Under the new-data policy, a written lane forwards the incoming byte.

The following can only be shown by the bench's scenarios, which run a reference memory model against two instances, one per policy:

- The masked lanes keep their stored bytes in memory.
- The old-data lane values appear during a write.
- The lane-to-bit mapping follows the FFFF/ABCD patterns.
- A write issued during a stall lands at the held address and leaves the presented address unchanged.

// File: rtl/bytelane_ram_pkg.sv
// Package: shared types for the byte-lane RAM.
// Assumes: nothing beyond IEEE 1800-2017.
package bytelane_ram_pkg;

    // Output policy for a written lane during a write cycle
    typedef enum logic {
        RDW_NEW_DATA = 1'b0,
        RDW_OLD_DATA = 1'b1
    } rdw_policy_e;

endpackage

// File: rtl/bl_addr_hold.sv
// Module: address register with stall feedback.
// A 2:1 mux in front of the register selects between the presented
// address and the register's own output; addr_stall is the select.
// Assumes: synchronous active-low reset, reset address is zero.
module bl_addr_hold #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_stall,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_q
);

    logic [ADDR_W-1:0] addr_next;

    // Hold mux: recirculate the current address while stalled
    always_comb begin
        addr_next = addr_stall ? addr_q : addr_in;
    end

    // Address register
    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_next;
    end

    // R7: a stalled edge keeps the address
    assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        addr_stall |=> (addr_q == $past(addr_q)));

    // R7: an unstalled edge loads the presented address
    assert_addr_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_stall |=> (addr_q == $past(addr_in)));

endmodule

// File: rtl/bl_ctrl_stage.sv
// Module: input stage for request, lane-enable and data.
// Aligns the command with the registered address so that the memory
// access happens one edge after capture.
// Assumes: synchronous active-low reset; requests clear on reset.
module bl_ctrl_stage #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [LANES-1:0]  lane_en,
    input  logic [WORD_W-1:0] wdata,
    output logic              wr_q,
    output logic              rd_q,
    output logic [LANES-1:0]  lane_q,
    output logic [WORD_W-1:0] wdata_q
);

    // Capture the command; reset cancels any pending access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            rd_q    <= 1'b0;
            lane_q  <= '0;
            wdata_q <= '0;
        end else begin
            wr_q    <= wr_en;
            rd_q    <= rd_en;
            lane_q  <= lane_en;
            wdata_q <= wdata;
        end
    end

endmodule

// File: rtl/bl_lane_mem.sv
// Module: one byte lane of storage with its registered output.
// Handles the write mask and the read-during-write selection for the lane.
// Assumes: inputs are already registered; storage is not reset.
module bl_lane_mem
    import bytelane_ram_pkg::*;
#(
    parameter int          ADDR_W = 9,
    parameter int          LANE_W = 8,
    parameter rdw_policy_e POLICY = RDW_NEW_DATA,
    localparam int         DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic              wr_q,
    input  logic              rd_q,
    input  logic              lane_q,
    input  logic [LANE_W-1:0] din_q,
    output logic [LANE_W-1:0] dout
);

    logic [LANE_W-1:0] store [DEPTH];
    logic [LANE_W-1:0] stored_byte;
    logic [LANE_W-1:0] write_view;

    assign stored_byte = store[addr_q];

    // Select what a written lane shows during the write
    generate
        if (POLICY == RDW_NEW_DATA) begin : g_new
            assign write_view = lane_q ? din_q : stored_byte;
        end else begin : g_old
            assign write_view = stored_byte;
        end
    endgenerate

    // Storage update, gated by the lane enable
    always_ff @(posedge clk) begin
        if (wr_q && lane_q) store[addr_q] <= din_q;
    end

    // Output register: write view, read data, or hold
    always_ff @(posedge clk) begin
        if (!rst_n)    dout <= '0;
        else if (wr_q) dout <= write_view;
        else if (rd_q) dout <= stored_byte;
    end

    // R1: reset clears the output
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (dout == '0));

    // R9: idle keeps the output
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_q && !rd_q) |=> $stable(dout));

    generate
        if (POLICY == RDW_NEW_DATA) begin : g_chk_new
            // R4: a written lane forwards the incoming byte
            assert_new_forward_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_q && lane_q) |=> (dout == $past(din_q)));
        end
    endgenerate

endmodule

// File: rtl/bytelane_ram.sv
// Module: byte-lane masked single-port RAM (top).
// Registers the address (with stall) and the command, then drives one
// storage bank per byte lane.
// Assumes: single clock, synchronous active-low reset, no storage init.
module bytelane_ram
    import bytelane_ram_pkg::*;
#(
    parameter int          ADDR_W     = 9,
    parameter int          LANE_W     = 8,
    parameter int          LANES      = 2,
    parameter rdw_policy_e RDW_POLICY = RDW_NEW_DATA,
    localparam int         WORD_W     = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [LANES-1:0]  lane_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_stall,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    logic [ADDR_W-1:0] addr_q;
    logic              wr_q;
    logic              rd_q;
    logic [LANES-1:0]  lane_q;
    logic [WORD_W-1:0] wdata_q;

    bl_addr_hold #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_stall (addr_stall),
        .addr_in    (addr),
        .addr_q     (addr_q)
    );

    bl_ctrl_stage #(.LANES(LANES), .LANE_W(LANE_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .lane_en (lane_en),
        .wdata   (wdata),
        .wr_q    (wr_q),
        .rd_q    (rd_q),
        .lane_q  (lane_q),
        .wdata_q (wdata_q)
    );

    // One bank per lane; lane i owns bits [i*LANE_W +: LANE_W]
    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            bl_lane_mem #(
                .ADDR_W (ADDR_W),
                .LANE_W (LANE_W),
                .POLICY (RDW_POLICY)
            ) u_bank (
                .clk    (clk),
                .rst_n  (rst_n),
                .addr_q (addr_q),
                .wr_q   (wr_q),
                .rd_q   (rd_q),
                .lane_q (lane_q[i]),
                .din_q  (wdata_q[i*LANE_W +: LANE_W]),
                .dout   (rdata[i*LANE_W +: LANE_W])
            );
        end
    endgenerate

endmodule

// File: tb/bytelane_ram_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: two instances (new-data and old-data policy) share
// the same stimulus; a reference memory predicts both outputs.
module bytelane_ram_bench;
    import bytelane_ram_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, addr_stall = 1'b0;
    logic [1:0]  lane_en = '0;
    logic [8:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata_new, rdata_old;

    always #2 clk = ~clk;  // 250 MHz

    bytelane_ram #(.RDW_POLICY(RDW_NEW_DATA)) u_bytelane_ram (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .lane_en(lane_en), .addr(addr), .addr_stall(addr_stall),
        .wdata(wdata), .rdata(rdata_new));

    bytelane_ram #(.RDW_POLICY(RDW_OLD_DATA)) u_bytelane_ram_old (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .lane_en(lane_en), .addr(addr), .addr_stall(addr_stall),
        .wdata(wdata), .rdata(rdata_old));

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          due;
        logic [15:0] exp_new;
        logic [15:0] exp_old;
        bit          kn_new;
        bit          kn_old;
        string       tag;
    } exp_t;

    exp_t sbq[$];
    int checks = 0;
    int errors = 0;

    logic [15:0] ref_mem [512];
    bit          ref_kn  [512];
    logic [8:0]  ref_addr = '0;
    logic [15:0] hold_new = '0, hold_old = '0;
    bit          hk_new = 1'b1, hk_old = 1'b1;

    task automatic check(string tag, string who, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, who, act, exp);
        end
    endtask

    // Monitor: compare results as they become due
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due == cyc) begin
            exp_t e;
            e = sbq.pop_front();
            if (e.kn_new) check(e.tag, "new-policy", rdata_new, e.exp_new);
            if (e.kn_old) check(e.tag, "old-policy", rdata_old, e.exp_old);
        end
    end

    // Driver: apply one command and push its predicted outputs
    task automatic op(bit we, bit rd, logic [1:0] be, logic [8:0] a,
                      logic [15:0] d, bit st, string tag);
        logic [8:0]  eff;
        logic [15:0] oldw, nw;
        bit          kn;
        exp_t        e;
        @(negedge clk);
        wr_en = we; rd_en = rd; lane_en = be; addr = a; wdata = d; addr_stall = st;
        eff = st ? ref_addr : a;
        ref_addr = eff;
        oldw = ref_mem[eff];
        kn = ref_kn[eff];
        if (we) begin
            nw = oldw;
            if (be[1]) nw[15:8] = d[15:8];
            if (be[0]) nw[7:0]  = d[7:0];
            hold_new = nw;
            hk_new = kn || (be == 2'b11);
            hold_old = oldw;
            hk_old = kn;
            ref_mem[eff] = nw;
            ref_kn[eff] = kn || (be == 2'b11);
        end else if (rd) begin
            hold_new = oldw; hk_new = kn;
            hold_old = oldw; hk_old = kn;
        end
        e.due = cyc + 2;
        e.exp_new = hold_new;
        e.exp_old = hold_old;
        e.kn_new = hk_new;
        e.kn_old = hk_old;
        e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements): actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) begin
            ref_mem[i] = '0;
            ref_kn[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: output cleared after reset
        check("R1", "new-policy", rdata_new, 16'h0000);
        check("R1", "old-policy", rdata_old, 16'h0000);
        op(0, 0, 2'b00, 9'd0, 16'h0000, 0, "R1");

        // R2: full-word initial writes
        op(1, 0, 2'b11, 9'd5,   16'hFFFF, 0, "R2");
        op(1, 0, 2'b11, 9'd6,   16'hFFFF, 0, "R2");
        op(1, 0, 2'b11, 9'd7,   16'hFFFF, 0, "R2");
        op(1, 0, 2'b11, 9'h1FF, 16'hFFFF, 0, "R2");
        op(0, 1, 2'b00, 9'd5,   16'h0000, 0, "R10");

        // R6/R3/R4/R5: masked patterns over FFFF
        op(1, 0, 2'b10, 9'd5, 16'hABCD, 0, "R6_R3_R4_R5");
        op(0, 1, 2'b00, 9'd5, 16'h0000, 0, "R6");
        op(1, 0, 2'b01, 9'd6, 16'hABCD, 0, "R6_R3_R4_R5");
        op(0, 1, 2'b00, 9'd6, 16'h0000, 0, "R6");
        op(1, 0, 2'b11, 9'd7, 16'hABCD, 0, "R6_R4_R5");
        op(0, 1, 2'b00, 9'd7, 16'h0000, 0, "R6");
        op(1, 0, 2'b00, 9'h1FF, 16'h1234, 0, "R3");
        op(0, 1, 2'b00, 9'h1FF, 16'h0000, 0, "R3");

        // R9: idle holds the output
        for (int i = 0; i < 3; i++) op(0, 0, 2'b11, 9'd6, 16'h5555, 0, "R9");

        // R7: stall keeps the address across several cycles
        op(0, 1, 2'b00, 9'd6, 16'h0000, 0, "R7");
        for (int i = 0; i < 3; i++) op(0, 1, 2'b00, 9'd7, 16'h0000, 1, "R7");

        // R8: a write during a stall goes to the held address
        op(1, 0, 2'b11, 9'd5, 16'h1234, 1, "R8");
        op(0, 1, 2'b00, 9'd5, 16'h0000, 0, "R8");
        op(0, 1, 2'b00, 9'd6, 16'h0000, 0, "R8");

        // Mixed lane patterns over a block of addresses
        for (int i = 0; i < 16; i++)
            op(1, 0, 2'b11, 9'(32 + i), 16'(i * 16'h1111), 0, "R2");
        for (int i = 0; i < 16; i++)
            op(1, 0, 2'(i), 9'(32 + i), ~16'(i * 16'h0F0F), 0, "R6_R3_R4_R5");
        for (int i = 0; i < 16; i++)
            op(0, 1, 2'b00, 9'(32 + i), 16'h0000, (i % 4) == 3, "R10_R7");

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule